// File: doc/BRIEF.md
# SPI Slave Receiver with Halt Wakeup

This block receives bytes as an SPI slave (clock idle low, data sampled on the rising serial clock edge, most significant bit first) and reports them to a processor through a transfer-complete flag, an overrun flag, a mode-fault flag and one combined interrupt request. The shift logic and the received-data register run on the external serial clock. Completion events cross into the system clock domain as a Gray-coded byte count through a two-flop synchronizer, so several bytes that finish while the system clock is stalled are still counted one by one.

The block also decides which events may end a low-power state. In light sleep, any flagged and enabled event ends the sleep. In deep halt, the system-side flags hold their values. Only a completed byte can raise the halt wakeup strobe, and only if slave select was low when halt was entered. After such a wakeup the block reports a post-halt state. This state lasts until one further byte completes, or until slave mode is switched off.

Top module: `spi_wake_slave`

## Requirements
- R1: While selected in slave mode, each group of DW rising `sck` edges forms one byte, first bit in the most significant position, and the eighth edge loads it into `rx_data`. Deselecting resets the bit counter.
- R2: A completed byte sets `done_flag` on the third rising `clk` edge after the completing `sck` edge.
- R3: `done_flag` is cleared by a `stat_rd` pulse (taken while a flag is set) followed by a `data_rd` pulse. A `data_rd` without a prior `stat_rd` leaves it set.
- R4: A byte that completes while `done_flag` is set, and is not being cleared in that cycle, sets `ovr_flag`. The same read sequence as in R3 clears `ovr_flag`.
- R5: When a byte completion and the clearing `data_rd` land in the same `clk` cycle, `done_flag` stays 1 and `ovr_flag` stays 0.
- R6: `fault_flag` sets when `master_cfg` is 1 and the effective select is low. A `stat_rd` then a `ctrl_wr` clears it; a `ctrl_wr` alone does not. The receiver ignores `sck` while `master_cfg` is 1.
- R7: `irq` equals `irq_en` and not `irq_mask`, and the OR of the three flags.
- R8: `wake_wait` equals `sleep_wait` and `irq`, so any of the three events ends light sleep.
- R9: With `ss_use_int`=1 the effective select is `ss_int_bit`, otherwise the `ss_n` pin; select is active low.
- R10: While `halt` is 1 the three flags hold, while bytes still load `rx_data`. After `halt` drops, pending bytes are processed one per `clk` cycle, and a second pending byte sets `ovr_flag`.
- R11: `wake_halt` is 1 during halt when select was low at halt entry, `irq_en`=1, `irq_mask`=0 and a byte has completed since the last processed one. Faults and overruns never raise it.
- R12: Leaving an armed halt sets `post_halt`. It clears when one byte completes after all bytes from the halt have been processed, or one edge after `slave_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select pin, active low |
| ss_use_int | input | 1 | 1 selects the internal select bit |
| ss_int_bit | input | 1 | Internal select value, active low |
| slave_en | input | 1 | Slave mode enable |
| master_cfg | input | 1 | Block configured as master |
| irq_en | input | 1 | Interrupt enable |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks |
| stat_rd | input | 1 | Status register read pulse |
| data_rd | input | 1 | Data register read pulse |
| ctrl_wr | input | 1 | Control register write pulse |
| sleep_wait | input | 1 | System is in light sleep |
| halt | input | 1 | System is in deep halt |
| rx_data | output | DW | Last received byte |
| done_flag | output | 1 | Transfer complete |
| ovr_flag | output | 1 | Overrun |
| fault_flag | output | 1 | Mode fault |
| irq | output | 1 | Combined interrupt request |
| wake_wait | output | 1 | Exit-from-sleep request |
| wake_halt | output | 1 | Exit-from-halt request |
| post_halt | output | 1 | Awaiting resynchronizing byte |

## Verification
A new byte's arrival in the system domain and the data read that acknowledges the previous byte can fall on the same `clk` edge. The bench provokes this by counting two edges past the last serial clock rise and driving `data_rd` so that it is sampled on the third. It then expects the transfer-complete flag to remain set, the overrun flag to remain clear, and the data register to hold the new byte. A second pairing is halt release with several pending bytes: these are processed in consecutive cycles, and the bench expects overrun after the second one.

// File: rtl/spi_wake_slave.sv
module spi_wake_slave #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          ss_n,
  input  logic          ss_use_int,
  input  logic          ss_int_bit,
  input  logic          slave_en,
  input  logic          master_cfg,
  input  logic          irq_en,
  input  logic          irq_mask,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          ctrl_wr,
  input  logic          sleep_wait,
  input  logic          halt,
  output logic [DW-1:0] rx_data,
  output logic          done_flag,
  output logic          ovr_flag,
  output logic          fault_flag,
  output logic          irq,
  output logic          wake_wait,
  output logic          wake_halt,
  output logic          post_halt
);
  localparam int BW = $clog2(DW);

  function automatic logic [CW-1:0] gray_inc(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    b = b + 1'b1;
    return b ^ (b >> 1);
  endfunction

  logic          sel_n, act, sck_rst_n;
  logic [BW-1:0] bitcnt;
  logic [DW-2:0] shreg;
  logic [CW-1:0] gcnt;

  assign sel_n     = ss_use_int ? ss_int_bit : ss_n;
  assign act       = slave_en & ~master_cfg & ~sel_n;
  assign sck_rst_n = rst_n & act;

  always_ff @(posedge sck or negedge sck_rst_n) begin
    if (!sck_rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      bitcnt <= (bitcnt == BW'(DW - 1)) ? '0 : bitcnt + 1'b1;
      shreg  <= {shreg[DW-3:0], mosi};
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      gcnt    <= '0;
    end else if (act && bitcnt == BW'(DW - 1)) begin
      rx_data <= {shreg, mosi};
      gcnt    <= gray_inc(gcnt);
    end
  end

  logic [CW-1:0] g1, g2, seen;
  logic          sl1, sl2, halt_q, armed, rd_armed, flt_armed, drained;
  logic          evt, clr;

  assign evt = ~halt & (g2 != seen);
  assign clr = data_rd & rd_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= '0; g2 <= '0; seen <= '0;
      sl1 <= 1'b1; sl2 <= 1'b1; halt_q <= 1'b0; armed <= 1'b0;
      rd_armed <= 1'b0; flt_armed <= 1'b0; drained <= 1'b0;
      done_flag <= 1'b0; ovr_flag <= 1'b0; fault_flag <= 1'b0; post_halt <= 1'b0;
    end else begin
      g1     <= gcnt;
      g2     <= g1;
      sl1    <= sel_n;
      sl2    <= sl1;
      halt_q <= halt;
      if (!halt)        armed <= 1'b0;
      else if (!halt_q) armed <= ~sl2;
      if (!halt) begin
        if (evt) seen <= gray_inc(seen);
        if (evt)      done_flag <= 1'b1;
        else if (clr) done_flag <= 1'b0;
        if (evt && done_flag && !clr) ovr_flag <= 1'b1;
        else if (clr)                 ovr_flag <= 1'b0;
        if (data_rd)                                rd_armed <= 1'b0;
        else if (stat_rd && (done_flag || ovr_flag)) rd_armed <= 1'b1;
        if (master_cfg && !sl2)         fault_flag <= 1'b1;
        else if (ctrl_wr && flt_armed)  fault_flag <= 1'b0;
        if (ctrl_wr)                    flt_armed <= 1'b0;
        else if (stat_rd && fault_flag) flt_armed <= 1'b1;
        if (halt_q && armed) begin
          post_halt <= 1'b1;
          drained   <= 1'b0;
        end else if (!slave_en) begin
          post_halt <= 1'b0;
        end else if (post_halt) begin
          if (!drained) begin
            if (!evt) drained <= 1'b1;
          end else if (evt) begin
            post_halt <= 1'b0;
          end
        end
      end
    end
  end

  assign irq       = irq_en & ~irq_mask & (done_flag | ovr_flag | fault_flag);
  assign wake_wait = sleep_wait & irq;
  assign wake_halt = halt & armed & irq_en & ~irq_mask & (gcnt != seen);
endmodule

module spi_wake_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic halt,
  input logic master_cfg,
  input logic data_rd,
  input logic ctrl_wr,
  input logic done_flag,
  input logic ovr_flag,
  input logic fault_flag,
  input logic post_halt
);
  // R4
  ovr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> done_flag);
  // R10
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> ($stable(done_flag) && $stable(ovr_flag) && $stable(fault_flag)));
  // R6
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> $past(master_cfg));
  // R6
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> $past(ctrl_wr));
  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(data_rd));
  // R12
  post_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(post_halt) |-> (!$past(halt) && $past(halt, 2)));
endmodule

bind spi_wake_slave spi_wake_slave_chk u_chk (.*);

// File: tb/sim_spi_wake_slave.sv
module sim_spi_wake_slave;
  logic clk = 0, rst_n = 0, sck = 0, mosi = 0, ss_n = 1, ss_use_int = 0, ss_int_bit = 1;
  logic slave_en = 1, master_cfg = 0, irq_en = 1, irq_mask = 0;
  logic stat_rd = 0, data_rd = 0, ctrl_wr = 0, sleep_wait = 0, halt = 0;
  logic [7:0] rx_data;
  logic done_flag, ovr_flag, fault_flag, irq, wake_wait, wake_halt, post_halt;
  int total = 0, bad = 0;
  bit ended = 0;

  spi_wake_slave u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit coll = 0);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = b[i];
      @(negedge clk) sck = 1;
      if (i == 0 && coll) begin
        @(posedge clk); @(posedge clk);
        @(negedge clk) data_rd = 1;
        @(negedge clk) data_rd = 0; sck = 0;
      end else begin
        @(negedge clk); @(negedge clk) sck = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_stat; @(negedge clk) stat_rd = 1; @(negedge clk) stat_rd = 0; endtask
  task automatic p_data; @(negedge clk) data_rd = 1; @(negedge clk) data_rd = 0; endtask
  task automatic p_ctrl; @(negedge clk) ctrl_wr = 1; @(negedge clk) ctrl_wr = 0; endtask
  task automatic clear_rx; p_stat(); p_data(); endtask

  task automatic make_fault;
    master_cfg = 1; idle(4); master_cfg = 0; idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // reset state
    chk("R2 reset done", done_flag, 0);
    chk("R4 reset ovr", ovr_flag, 0);
    chk("R6 reset fault", fault_flag, 0);
    chk("R7 reset irq", irq, 0);
    chk("R11 reset wake", wake_halt, 0);
    chk("R12 reset post", post_halt, 0);
    chk("R1 reset data", rx_data, 0);

    ss_n = 0; idle(3);
    // R1 R2 R3 exhaustive byte sweep
    for (int v = 0; v < 256; v++) begin
      send(v[7:0]);
      idle(4);
      chk("R1 byte", rx_data, v);
      chk("R2 done set", done_flag, 1);
      clear_rx();
      chk("R3 done cleared", done_flag, 0);
    end

    // R2 exact latency: done appears on third clk edge after last sck rise
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = i[0];
      @(negedge clk) sck = 1;
      if (i != 0) begin @(negedge clk); @(negedge clk) sck = 0; end
    end
    @(posedge clk); @(posedge clk); #1;
    chk("R2 not yet after two edges", done_flag, 0);
    @(posedge clk); #1;
    chk("R2 set on third edge", done_flag, 1);
    @(negedge clk) sck = 0;
    clear_rx();

    // R3 data read alone does not clear
    send(8'h3C); idle(4);
    p_data();
    chk("R3 data read alone", done_flag, 1);
    clear_rx();
    chk("R3 sequence clears", done_flag, 0);

    // R4 overrun
    send(8'hA1); idle(4);
    send(8'h5E); idle(4);
    chk("R4 ovr set", ovr_flag, 1);
    chk("R4 done still", done_flag, 1);
    chk("R4 data is newest", rx_data, 8'h5E);
    clear_rx();
    chk("R4 ovr cleared", ovr_flag, 0);
    chk("R4 done cleared", done_flag, 0);

    // R5 completion coincides with clearing read
    send(8'h11); idle(4);
    p_stat();
    send(8'h22, 1); idle(3);
    chk("R5 done kept", done_flag, 1);
    chk("R5 no ovr", ovr_flag, 0);
    chk("R5 data", rx_data, 8'h22);
    clear_rx();

    // R6 mode fault
    make_fault();
    chk("R6 fault set", fault_flag, 1);
    chk("R6 done untouched", done_flag, 0);
    p_ctrl();
    chk("R6 ctrl alone", fault_flag, 1);
    p_stat(); p_ctrl();
    chk("R6 cleared", fault_flag, 0);
    master_cfg = 1; idle(4);
    send(8'hF0); idle(4);
    master_cfg = 0; idle(2);
    chk("R6 master ignores sck", rx_data, 8'h22);
    p_stat(); p_ctrl();
    chk("R6 cleared again", fault_flag, 0);

    // R7 R8 irq and wake_wait sweep over flag states
    for (int st = 0; st < 4; st++) begin
      irq_en = 1; irq_mask = 0;
      if (st == 1) begin send(8'h01); idle(4); end
      if (st == 2) begin send(8'h02); idle(4); send(8'h03); idle(4); end
      if (st == 3) make_fault();
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 2; s++) begin
            @(negedge clk) irq_en = e[0]; irq_mask = m[0]; sleep_wait = s[0];
            #1;
            chk("R7 irq", irq, (st != 0) && e == 1 && m == 0);
            chk("R8 wake_wait", wake_wait, (st != 0) && e == 1 && m == 0 && s == 1);
          end
      irq_en = 1; irq_mask = 0; sleep_wait = 0;
      if (st == 3) begin p_stat(); p_ctrl(); end
      else if (st != 0) clear_rx();
      chk("R7 flags clear", {done_flag, ovr_flag, fault_flag}, 0);
    end

    // R9 internal select
    ss_use_int = 1; ss_int_bit = 0; ss_n = 1; idle(3);
    send(8'h9D); idle(4);
    chk("R9 internal low receives", rx_data, 8'h9D);
    clear_rx();
    ss_int_bit = 1; ss_n = 0; idle(3);
    send(8'h44); idle(4);
    chk("R9 internal high ignores", rx_data, 8'h9D);
    chk("R9 no done", done_flag, 0);
    ss_use_int = 0; idle(3);

    // R10 R11 R12 armed halt wakeup
    @(negedge clk) halt = 1; idle(3);
    chk("R11 no wake idle", wake_halt, 0);
    send(8'hB7); idle(2);
    chk("R11 wake on byte", wake_halt, 1);
    chk("R10 flags frozen", done_flag, 0);
    chk("R10 data loaded in halt", rx_data, 8'hB7);
    irq_mask = 1; #1;
    chk("R11 mask blocks wake", wake_halt, 0);
    irq_mask = 0; #1;
    chk("R11 unmask wake", wake_halt, 1);
    @(negedge clk) halt = 0; idle(3);
    chk("R10 done after release", done_flag, 1);
    chk("R10 no ovr single", ovr_flag, 0);
    chk("R12 post set", post_halt, 1);
    chk("R11 wake dropped", wake_halt, 0);
    clear_rx();
    chk("R12 post holds", post_halt, 1);
    send(8'h66); idle(4);
    chk("R12 post cleared by extra byte", post_halt, 0);
    clear_rx();

    // R10 two bytes in halt, R12 slave_en exit
    @(negedge clk) halt = 1; idle(3);
    send(8'h10); send(8'h20); idle(2);
    chk("R10 frozen two bytes", {done_flag, ovr_flag}, 0);
    @(negedge clk) halt = 0; idle(3);
    chk("R10 ovr from pending", ovr_flag, 1);
    chk("R10 done pending", done_flag, 1);
    chk("R10 last data", rx_data, 8'h20);
    chk("R12 post set again", post_halt, 1);
    slave_en = 0; idle(2);
    chk("R12 slave_en clears post", post_halt, 0);
    slave_en = 1;
    clear_rx();

    // R11 disarmed: select high at halt entry
    ss_n = 1; idle(3);
    @(negedge clk) halt = 1; idle(3);
    ss_n = 0; idle(1);
    send(8'hC3); idle(2);
    chk("R11 disarmed no wake", wake_halt, 0);
    @(negedge clk) halt = 0; idle(3);
    chk("R11 disarmed still received", done_flag, 1);
    chk("R11 disarmed data", rx_data, 8'hC3);
    chk("R12 no post when disarmed", post_halt, 0);
    clear_rx();

    // R11 fault pending does not wake halt
    make_fault();
    @(negedge clk) halt = 1; idle(3);
    chk("R11 fault no halt wake", wake_halt, 0);
    chk("R10 fault frozen", fault_flag, 1);
    @(negedge clk) halt = 0; idle(2);
    p_stat(); p_ctrl();
    chk("R6 fault cleared end", fault_flag, 0);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule